// File: doc/BRIEF.md
# Programmable Radio Bit-Rate Generator

This block derives the bit clock of a radio modem from a slow reference enable. The reference is a one-cycle strobe that arrives at a fixed sub-rate of the system clock, nominally a 10 MHz crystal divided by 29, or about 344.8 kHz. An 8-bit rate setting picks the output rate. Its low seven bits hold a divisor `R`, and the bit period is `R+1` reference strobes. Its top bit adds a further divide-by-eight prescale stage. The output is a single-cycle `bit_tick_o` pulse, and the modem advances one symbol on each pulse.

Software writes the rate setting through a write strobe at any time. The written value is held as pending and becomes active only when the current bit period completes, so a rate change never produces a shortened or stretched bit. After reset the active setting is 0x23, which gives `R = 35` with no prescale: a period of 36 strobes, about 9.58 kbit/s.

Top module: `radio_bitrate_gen`

## Requirements
- R1: A synchronous reset (rst_i high at a clock edge) loads the active setting 0x23, clears any pending setting and both counters, and holds bit_tick_o low; with strobes on every cycle afterwards, the first tick follows the 36th strobe.
- R2: With setting bit 7 at 0, a bit period is exactly R+1 reference strobes, where R is setting bits [6:0].
- R3: With setting bit 7 at 1, a bit period is exactly 8*(R+1) reference strobes.
- R4: bit_tick_o is high for one cycle per completed period, in the cycle after the clock edge that sampled the strobe completing the period, and is never high unless ref_en_i was high at the previous edge.
- R5: A written setting does not change the active setting during a bit; the bit in progress completes with the old period and the new setting governs the next bit.
- R6: A write sampled at the same edge as a period-completing strobe is applied at the following boundary, not at this one; of several writes within one bit, only the last is applied.
- R7: With setting 0x00, every reference strobe produces a tick, including strobes on back-to-back cycles.
- R8: Only cycles with ref_en_i high advance the period; gaps of any length between strobes stretch time but not the strobe count.
- R9: A reset in the middle of a bit discards the partial count and any pending setting, and timing restarts from R1's state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_en_i | input | 1 | One-cycle reference strobe at the base rate |
| cfg_wr_i | input | 1 | Write strobe for the rate setting |
| cfg_data_i | input | 8 | Rate setting: bit 7 prescale select, bits [6:0] divisor R |
| bit_tick_o | output | 1 | One-cycle pulse at each bit boundary |

## Verification
The bench builds the block with its default parameters: a 7-bit divisor and a prescale factor of 8. At these sizes the longest period is 1024 strobes, so every divisor value 0 to 127 can be swept without prescale, and a span of divisors plus the maximum can be swept with prescale, all in a few tens of thousands of cycles. A pseudo-random strobe pattern and random mid-bit writes with small divisors make boundary-coincident writes and long strobe gaps occur many times within the run. Each result is compared against a period count that the bench computes arithmetically from the setting.

// File: rtl/brg_pkg.sv
`timescale 1ns/1ps
package brg_pkg;

    // Default geometry of the rate setting.
    localparam int unsigned DEF_DIV_W      = 7;
    localparam int unsigned DEF_PRE_FACTOR = 8;
    localparam logic [7:0]  DEF_RESET_CFG  = 8'h23;

    // Whether the extra prescale stage sits in the strobe path.
    typedef enum logic {
        PRE_BYPASS  = 1'b0,
        PRE_ENGAGED = 1'b1
    } pre_mode_e;

endpackage

// File: rtl/brg_cfg_hold.sv
`timescale 1ns/1ps
module brg_cfg_hold #(
    parameter int unsigned      CFG_W     = 8,
    parameter logic [CFG_W-1:0] RESET_CFG = 8'h23
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    input  logic             boundary_i,
    output logic [CFG_W-1:0] act_cfg_o
);

    typedef struct packed {
        logic [CFG_W-1:0] act;
        logic [CFG_W-1:0] pend;
        logic             pend_vld;
    } hold_t;

    hold_t state_d;
    hold_t state_q;

    always_comb begin
        state_d = state_q;
        // The bit ending now hands over to the value held before this edge.
        if (boundary_i && state_q.pend_vld) begin
            state_d.act      = state_q.pend;
            state_d.pend_vld = 1'b0;
        end
        // A write lands in the holding slot; it waits for the next boundary.
        if (wr_i) begin
            state_d.pend     = wdata_i;
            state_d.pend_vld = 1'b1;
        end
        if (rst_i) begin
            state_d.act      = RESET_CFG;
            state_d.pend     = RESET_CFG;
            state_d.pend_vld = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign act_cfg_o = state_q.act;

endmodule

// File: rtl/brg_prescale.sv
`timescale 1ns/1ps
module brg_prescale
    import brg_pkg::*;
#(
    parameter int unsigned PRE_FACTOR = 8
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      ref_en_i,
    input  pre_mode_e mode_i,
    input  logic      boundary_i,
    output logic      stage_en_o
);

    localparam int unsigned PRE_W = (PRE_FACTOR > 1) ? $clog2(PRE_FACTOR) : 1;

    generate
        if (PRE_FACTOR <= 1) begin : g_bypass
            logic unused_pre;
            assign unused_pre = ^{clk_i, rst_i, mode_i, boundary_i};
            assign stage_en_o = ref_en_i;
        end else begin : g_count
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_FACTOR - 1);

            typedef struct packed {
                logic [PRE_W-1:0] cnt;
            } pre_t;

            pre_t state_d;
            pre_t state_q;
            logic last_w;

            assign last_w     = (state_q.cnt == PRE_LAST);
            assign stage_en_o = ref_en_i && ((mode_i == PRE_BYPASS) || last_w);

            always_comb begin
                state_d = state_q;
                if (ref_en_i && (mode_i == PRE_ENGAGED)) begin
                    state_d.cnt = last_w ? '0 : state_q.cnt + 1'b1;
                end
                // A new bit always starts its prescale phase from zero.
                if (boundary_i || (mode_i == PRE_BYPASS) || rst_i) begin
                    state_d.cnt = '0;
                end
            end

            always_ff @(posedge clk_i) begin
                state_q <= state_d;
            end
        end
    endgenerate

endmodule

// File: rtl/brg_divider.sv
`timescale 1ns/1ps
module brg_divider #(
    parameter int unsigned DIV_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             stage_en_i,
    input  logic [DIV_W-1:0] limit_i,
    output logic             wrap_o,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_t;

    div_t state_d;
    div_t state_q;

    assign wrap_o = stage_en_i && (state_q.cnt == limit_i);

    always_comb begin
        state_d      = state_q;
        state_d.tick = wrap_o;
        if (stage_en_i) begin
            state_d.cnt = wrap_o ? '0 : state_q.cnt + 1'b1;
        end
        if (rst_i) begin
            state_d.cnt  = '0;
            state_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign tick_o = state_q.tick;

endmodule

// File: rtl/radio_bitrate_gen.sv
`timescale 1ns/1ps
module radio_bitrate_gen
    import brg_pkg::*;
#(
    parameter int unsigned     DIV_W      = DEF_DIV_W,
    parameter int unsigned     PRE_FACTOR = DEF_PRE_FACTOR,
    parameter logic [DIV_W:0]  RESET_CFG  = DEF_RESET_CFG
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             ref_en_i,
    input  logic             cfg_wr_i,
    input  logic [DIV_W:0]   cfg_data_i,
    output logic             bit_tick_o
);

    localparam int unsigned CFG_W = DIV_W + 1;

    logic [CFG_W-1:0] act_cfg;
    logic             stage_en;
    logic             wrap;
    pre_mode_e        pre_mode;

    assign pre_mode = act_cfg[DIV_W] ? PRE_ENGAGED : PRE_BYPASS;

    brg_cfg_hold #(
        .CFG_W     (CFG_W),
        .RESET_CFG (RESET_CFG)
    ) u_cfg (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_i       (cfg_wr_i),
        .wdata_i    (cfg_data_i),
        .boundary_i (wrap),
        .act_cfg_o  (act_cfg)
    );

    brg_prescale #(
        .PRE_FACTOR (PRE_FACTOR)
    ) u_pre (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ref_en_i   (ref_en_i),
        .mode_i     (pre_mode),
        .boundary_i (wrap),
        .stage_en_o (stage_en)
    );

    brg_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .stage_en_i (stage_en),
        .limit_i    (act_cfg[DIV_W-1:0]),
        .wrap_o     (wrap),
        .tick_o     (bit_tick_o)
    );

endmodule

// File: rtl/brg_checker.sv
`timescale 1ns/1ps
module brg_checker #(
    parameter int unsigned    DIV_W      = 7,
    parameter int unsigned    PRE_FACTOR = 8,
    parameter logic [DIV_W:0] RESET_CFG  = 8'h23
) (
    input logic           clk_i,
    input logic           rst_i,
    input logic           ref_en_i,
    input logic           bit_tick_i,
    input logic [DIV_W:0] act_cfg_i
);

    function automatic int unsigned period_of(input logic [DIV_W:0] c);
        int unsigned base;
        base = int'(c[DIV_W-1:0]) + 1;
        return c[DIV_W] ? base * PRE_FACTOR : base;
    endfunction

    int unsigned en_cnt_q;
    int unsigned per_q;
    logic        rst_seen_q;

    always_ff @(posedge clk_i) begin
        rst_seen_q <= rst_i;
        if (rst_i) begin
            en_cnt_q <= 0;
            per_q    <= period_of(RESET_CFG);
        end else begin
            en_cnt_q <= (bit_tick_i ? 0 : en_cnt_q) + (ref_en_i ? 1 : 0);
            if (bit_tick_i) begin
                per_q <= period_of(act_cfg_i);
            end
        end
    end

    // R1: the edge after a reset cycle shows the reset setting and no tick.
    always @(posedge clk_i) begin
        if (rst_seen_q === 1'b1) begin
            assert_reset_cfg_R1: assert (act_cfg_i == RESET_CFG && !bit_tick_i)
                else $error("reset state wrong");
        end
    end

    // R2 and R3: the strobes counted between ticks equal the period of the bit.
    assert_period_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_tick_i |-> (en_cnt_q == per_q));

    assert_tick_after_ref_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_tick_i |-> $past(ref_en_i));

    assert_cfg_stable_midbit_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !bit_tick_i |-> $stable(act_cfg_i));

    assert_zero_divisor_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (ref_en_i && act_cfg_i == '0) |=> bit_tick_i);

endmodule

bind radio_bitrate_gen brg_checker #(
    .DIV_W      (DIV_W),
    .PRE_FACTOR (PRE_FACTOR),
    .RESET_CFG  (RESET_CFG)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .ref_en_i   (ref_en_i),
    .bit_tick_i (bit_tick_o),
    .act_cfg_i  (act_cfg)
);

// File: tb/radio_bitrate_gen_tb.sv
`timescale 1ns/1ps
module radio_bitrate_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_en = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       tick;

    always #4 clk = ~clk;

    radio_bitrate_gen u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .ref_en_i   (ref_en),
        .cfg_wr_i   (wr),
        .cfg_data_i (wdata),
        .bit_tick_o (tick)
    );

    int    checks = 0;
    int    fails  = 0;
    string req    = "R1";

    // Requirement-level model: settings and a strobe count.
    int   m_act  = 'h23;
    int   m_pend = 0;
    bit   m_pv   = 0;
    int   m_cnt  = 0;
    bit   m_exp  = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int period(input int c);
        return ((c & 'h7F) + 1) * (((c & 'h80) != 0) ? 8 : 1);
    endfunction

    task automatic check(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
        end
    endtask

    task automatic step();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // One cycle: check the tick caused by last cycle's inputs, then drive new ones.
    task automatic cycle(input bit r, input bit e, input bit w, input logic [7:0] d);
        @(negedge clk);
        if (m_exp || tick !== 1'b0)
            check(tick === m_exp, req, int'(tick), int'(m_exp));
        rst = r; ref_en = e; wr = w; wdata = d;
        m_exp = 0;
        if (r) begin
            m_act = 'h23; m_pv = 0; m_cnt = 0;
        end else begin
            if (e) begin
                m_cnt++;
                if (m_cnt == period(m_act)) begin
                    m_exp = 1; m_cnt = 0;
                    if (m_pv) begin m_act = m_pend; m_pv = 0; end
                end
            end
            if (w) begin m_pend = int'(d); m_pv = 1; end
        end
    endtask

    task automatic run(input int n, input bit gapped);
        for (int i = 0; i < n; i++) begin
            step();
            cycle(1'b0, gapped ? lfsr[0] & lfsr[3] : 1'b1, 1'b0, 8'h00);
        end
    endtask

    task automatic do_reset(input int n);
        for (int i = 0; i < n; i++) cycle(1'b1, 1'b1, 1'b1, 8'h55);
        @(negedge clk);
        check(tick === 1'b0, "R1 tick low in reset", int'(tick), 0);
        m_exp = 0;
        rst = 1'b0; ref_en = 1'b0; wr = 1'b0;
    endtask

    task automatic set_cfg(input logic [7:0] d);
        cycle(1'b0, 1'b0, 1'b1, d);
    endtask

    initial begin
        int first;
        // R1: reset state and first period of 36 strobes.
        req = "R1";
        do_reset(3);
        first = -1;
        for (int i = 1; i <= 40; i++) begin
            cycle(1'b0, 1'b1, 1'b0, 8'h00);
            if (tick === 1'b1 && first < 0) first = i - 1;
        end
        check(first == 36, "R1 first tick after strobe count", first, 36);

        // R2 and R7: divisor sweep without prescale, continuous strobes.
        for (int r = 0; r < 128; r++) begin
            req = (r == 0) ? "R7" : "R2";
            set_cfg(8'(r));
            run(period(m_act) + 3 * (r + 1) + 2, 1'b0);
        end

        // R3: prescale sweep plus the maximum setting.
        req = "R3";
        for (int r = 0; r < 16; r++) begin
            set_cfg(8'(8'h80 | r));
            run(period(m_act) + 3 * 8 * (r + 1) + 2, 1'b0);
        end
        set_cfg(8'hFF);
        run(period(m_act) + 2 * 1024 + 2, 1'b0);

        // R8: gapped strobes with and without prescale.
        req = "R8";
        set_cfg(8'h05);
        run(period(m_act) * 4 + 1500, 1'b1);
        set_cfg(8'h83);
        run(2500, 1'b1);

        // R6: write coinciding with the boundary strobe waits one more bit.
        req = "R6";
        do_reset(2);
        for (int i = 0; i < 35; i++) cycle(1'b0, 1'b1, 1'b0, 8'h00);
        cycle(1'b0, 1'b1, 1'b1, 8'h01);
        run(80, 1'b0);

        // R5 and R6: random writes at random times with small periods.
        req = "R5";
        for (int i = 0; i < 4000; i++) begin
            step();
            cycle(1'b0, lfsr[1] | lfsr[5], (lfsr[7:4] == 4'h3), lfsr[15:8] & 8'h83);
        end
        run(2 * 1024, 1'b0);

        // R9: reset in the middle of a bit.
        req = "R9";
        set_cfg(8'h0A);
        run(period(m_act) + 5, 1'b0);
        set_cfg(8'h02);
        do_reset(2);
        run(110, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule